// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives a character LCD of the common HD44780 type on behalf of a host that only issues byte writes. The host presents a byte together with a register-select bit (address bit 0): a 0 writes the command register and a 1 writes the data register, so the display occupies two neighbouring addresses. The controller drives the register-select, read/write, enable and data lines. It enforces the minimum enable pulse width and the spacing between enable pulses, and it waits after each command until the display can take the next one.

After reset the controller keeps the display quiet for a power-up delay. It then sends an initialization sequence on its own: the function-set command three times, the final bus-width setting, display on, clear and entry mode. Only then does it raise `ready` for the host. A parameter selects an 8-bit data bus or a 4-bit bus that uses only the upper four data lines. All timings are derived from a clock-frequency parameter by rounding up to whole cycles.

Top module: `lcd_wr_ctrl`

## Requirements
- R1: For every transfer, `lcd_rs` equals the register-select bit of the host write: 0 for a command and 1 for data. Initialization steps are commands, with `lcd_rs` = 0.
- R2: `lcd_rw` is 0 (write) whenever `lcd_e` is high.
- R3: Each high pulse of `lcd_e` lasts at least ceil(140 ns × CLK_HZ) cycles, and at least one cycle.
- R4: Two consecutive rising edges of `lcd_e` are at least ceil(1200 ns × CLK_HZ) cycles apart. This includes the two nibbles of one byte in 4-bit mode.
- R5: After reset, `lcd_e` stays low and `ready` stays low for at least the power-up time. That time is POWERUP_US microseconds, raised to 40000 µs when POWERUP_US is smaller.
- R6: In 8-bit mode (BUS4 = 0), the initialization writes full bytes 0x30, 0x30, 0x30, 0x38, 0x0C, 0x01 and 0x06, in that order, on `lcd_db[7:0]`.
- R7: In 4-bit mode (BUS4 = 1), the initialization writes four single nibbles 0x3, 0x3, 0x3 and 0x2. It then writes the bytes 0x28, 0x0C, 0x01 and 0x06, each as two nibbles.
- R8: In 4-bit mode, every byte is sent as two enable pulses, upper nibble first, on `lcd_db[7:4]`. `lcd_db[3:0]` is 0 while `lcd_e` is high.
- R9: After a full-byte command 0x01 or 0x02 with register select 0, at least ceil(1.52 ms × CLK_HZ) cycles pass before the next enable pulse and before `ready` returns. After any other transfer the wait is ceil(37 µs × CLK_HZ) cycles.
- R10: `ready` is high only while the controller is idle. A write with `wr_en` high is taken only while `ready` is high, and `ready` is low in the following cycle.
- R11: `lcd_e` pulses only for taken host writes and for initialization steps. A write presented while `ready` is low produces no pulse. `lcd_db` and `lcd_rs` do not change while `lcd_e` is high.
- R12: Reset during any activity returns the controller to the power-up wait, after which the full initialization runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_rs | input | 1 | Register select (address bit 0): 0 command, 1 data |
| wr_data | input | 8 | Byte to write |
| ready | output | 1 | High when idle and able to take a write |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, held at write (0) |
| lcd_db | output | 8 | Display data lines; only [7:4] carry data in 4-bit mode |

## Verification
Some properties are checked on every cycle by the assertions: the minimum enable width, the rise-to-rise spacing, data and select held stable during a pulse, silence during the power-up wait, no pulse while `ready` is high, and `ready` dropping after a write is taken. The bench scenarios check the rest. They compare the initialization order in both bus widths, the nibble order and the register-select value, and the long wait after clear and home against the shorter wait. They also confirm that writes presented while busy never reach the display, that the power-up time is raised to its minimum, and that a reset in the middle of a transfer restarts initialization.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

    typedef enum logic [2:0] {
        SQ_PWR,
        SQ_INIT_GO,
        SQ_INIT_WAIT,
        SQ_IDLE,
        SQ_HOST
    } seq_state_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_SLOT,
        EN_WAIT
    } eng_state_t;

    // One transfer toward the display
    typedef struct packed {
        logic [7:0] code;
        logic       rs;
        logic       nib_only;   // 4-bit mode: send the upper nibble only
    } lcd_xfer_t;

    // Nanoseconds to clock cycles, rounded up, at least one
    function automatic int ns_to_cyc(longint ns, longint hz);
        longint c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Clear and home need the extended settle time
    function automatic logic needs_long(lcd_xfer_t x);
        return !x.rs && !x.nib_only && (x.code == 8'h01 || x.code == 8'h02);
    endfunction

    // Value placed on the data lines for the given half of a transfer
    function automatic logic [7:0] bus_lane(bit bus4, logic [7:0] code, logic low_half);
        if (!bus4)
            return code;
        return low_half ? {code[3:0], 4'h0} : {code[7:4], 4'h0};
    endfunction

endpackage

// File: rtl/lcd_delay_cnt.sv
module lcd_delay_cnt #(
    parameter int CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(CYCLES - 1))
                expired <= 1'b1;
        end
    end

    // R5
    pwr_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> cnt == CW'(CYCLES));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_wr_pkg::*;
#(
    parameter bit BUS4 = 1'b0
) (
    input  logic [2:0] idx,
    output lcd_xfer_t  step
);
    generate
        if (BUS4) begin : g_nib
            always_comb begin
                step.rs       = 1'b0;
                step.nib_only = (idx <= 3'd3);
                case (idx)
                    3'd0, 3'd1, 3'd2: step.code = 8'h30;
                    3'd3:             step.code = 8'h20;
                    3'd4:             step.code = 8'h28;
                    3'd5:             step.code = 8'h0C;
                    3'd6:             step.code = 8'h01;
                    default:          step.code = 8'h06;
                endcase
            end
        end else begin : g_byte
            always_comb begin
                step.rs       = 1'b0;
                step.nib_only = 1'b0;
                case (idx)
                    3'd0, 3'd1, 3'd2: step.code = 8'h30;
                    3'd3:             step.code = 8'h38;
                    3'd4:             step.code = 8'h0C;
                    3'd5:             step.code = 8'h01;
                    default:          step.code = 8'h06;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_strobe_engine.sv
module lcd_strobe_engine
    import lcd_wr_pkg::*;
#(
    parameter bit BUS4      = 1'b0,
    parameter int E_CYC     = 1,
    parameter int SPACE_CYC = 2,
    parameter int SLOT_CYC  = 3,
    parameter int SHORT_CYC = 37,
    parameter int LONG_CYC  = 1520
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  lcd_xfer_t  req,
    output logic       busy,
    output logic       done,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic [7:0] lcd_db
);
    localparam int SW = $clog2(SLOT_CYC + 1);
    localparam int WW = $clog2(LONG_CYC + 1);
    localparam int GW = $clog2(SPACE_CYC + 1);

    eng_state_t      st;
    logic [SW-1:0]   scnt;
    logic [WW-1:0]   wcnt;
    lcd_xfer_t       cur;
    logic            second;
    logic            last_slot;
    logic            more;

    assign last_slot = (scnt == SW'(SLOT_CYC - 1));
    assign more      = BUS4 && !cur.nib_only && !second;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            scnt   <= '0;
            wcnt   <= '0;
            cur    <= '0;
            second <= 1'b0;
            lcd_rs <= 1'b0;
            lcd_db <= '0;
        end else begin
            case (st)
                EN_IDLE: begin
                    if (start) begin
                        cur    <= req;
                        second <= 1'b0;
                        scnt   <= '0;
                        lcd_rs <= req.rs;
                        lcd_db <= bus_lane(BUS4, req.code, 1'b0);
                        st     <= EN_SLOT;
                    end
                end
                EN_SLOT: begin
                    if (last_slot) begin
                        if (more) begin
                            second <= 1'b1;
                            scnt   <= '0;
                            lcd_db <= bus_lane(BUS4, cur.code, 1'b1);
                        end else begin
                            wcnt <= needs_long(cur) ? WW'(LONG_CYC - 1) : WW'(SHORT_CYC - 1);
                            st   <= EN_WAIT;
                        end
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                EN_WAIT: begin
                    if (wcnt == '0)
                        st <= EN_IDLE;
                    else
                        wcnt <= wcnt - 1'b1;
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // Slot: cycle 0 sets up data, cycles 1..E_CYC strobe, the rest hold
    assign lcd_e = (st == EN_SLOT) && (scnt != '0) && (scnt <= SW'(E_CYC));
    assign busy  = (st != EN_IDLE);
    assign done  = (st == EN_WAIT) && (wcnt == '0);

    // Checker state: pulse width and spacing since the last rising edge
    logic          e_prev;
    logic [SW-1:0] hi_cnt;
    logic [GW-1:0] gap;
    logic          seen_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_prev    <= 1'b0;
            hi_cnt    <= '0;
            gap       <= '0;
            seen_rise <= 1'b0;
        end else begin
            e_prev <= lcd_e;
            hi_cnt <= lcd_e ? hi_cnt + 1'b1 : '0;
            if (lcd_e && !e_prev) begin
                gap       <= GW'(1);
                seen_rise <= 1'b1;
            end else if (gap < GW'(SPACE_CYC)) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R3
    e_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!lcd_e && e_prev) |-> hi_cnt >= SW'(E_CYC));

    // R4
    e_space_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && !e_prev && seen_rise) |-> gap >= GW'(SPACE_CYC));

    // R11
    e_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && e_prev) |-> ($stable(lcd_db) && $stable(lcd_rs)));

endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl
    import lcd_wr_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter bit BUS4       = 1'b0,
    parameter int POWERUP_US = 100_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_rs,
    input  logic [7:0] wr_data,
    output logic       ready,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic [7:0] lcd_db
);
    localparam longint HZ        = longint'(CLK_HZ);
    localparam int     E_CYC     = ns_to_cyc(140, HZ);
    localparam int     SPACE_CYC = ns_to_cyc(1200, HZ);
    localparam int     SLOT_CYC  = max_int(SPACE_CYC, E_CYC + 2);
    localparam int     SHORT_CYC = ns_to_cyc(37_000, HZ);
    localparam int     LONG_CYC  = ns_to_cyc(1_520_000, HZ);
    localparam int     PWR_US    = max_int(POWERUP_US, 40_000);
    localparam int     PWR_CYC   = ns_to_cyc(longint'(PWR_US) * 1000, HZ);
    localparam int     INIT_LEN  = BUS4 ? 8 : 7;

    seq_state_t state;
    logic [2:0] idx;
    logic       pwr_done;
    lcd_xfer_t  step;
    lcd_xfer_t  req;
    logic       start;
    logic       eng_busy;
    logic       eng_done;

    lcd_delay_cnt #(.CYCLES(PWR_CYC)) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .expired (pwr_done)
    );

    lcd_init_seq #(.BUS4(BUS4)) u_seq (
        .idx  (idx),
        .step (step)
    );

    always_comb begin
        if (state == SQ_IDLE) begin
            req.code     = wr_data;
            req.rs       = wr_rs;
            req.nib_only = 1'b0;
        end else begin
            req = step;
        end
    end

    assign start = (state == SQ_INIT_GO) || (state == SQ_IDLE && wr_en);

    lcd_strobe_engine #(
        .BUS4      (BUS4),
        .E_CYC     (E_CYC),
        .SPACE_CYC (SPACE_CYC),
        .SLOT_CYC  (SLOT_CYC),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req    (req),
        .busy   (eng_busy),
        .done   (eng_done),
        .lcd_e  (lcd_e),
        .lcd_rs (lcd_rs),
        .lcd_db (lcd_db)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_PWR;
            idx   <= '0;
        end else begin
            case (state)
                SQ_PWR:       if (pwr_done) state <= SQ_INIT_GO;
                SQ_INIT_GO:   state <= SQ_INIT_WAIT;
                SQ_INIT_WAIT: begin
                    if (eng_done) begin
                        if (idx == 3'(INIT_LEN - 1)) begin
                            state <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_INIT_GO;
                        end
                    end
                end
                SQ_IDLE:      if (wr_en) state <= SQ_HOST;
                SQ_HOST:      if (eng_done) state <= SQ_IDLE;
                default:      state <= SQ_PWR;
            endcase
        end
    end

    assign ready  = (state == SQ_IDLE);
    assign lcd_rw = 1'b0;

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && wr_en) |=> !ready);

    // R11
    e_idle_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> !ready);

    // R5
    pwr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_done |-> (!lcd_e && !ready));

    // R10
    start_free_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !eng_busy);

endmodule

// File: tb/lcd_wr_ctrl_test.sv
module lcd_wr_ctrl_mon #(
    parameter bit BUS4   = 1'b0,
    parameter int E_MIN  = 1,
    parameter int SP_MIN = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       e,
    input logic       rs,
    input logic       rw,
    input logic [7:0] db
);
    int         cyc;
    int         hi_w;
    int         last_rise;
    bit         seen;
    logic       e_d;
    int         n;
    logic [7:0] val [256];
    logic       vrs [256];
    int         rt  [256];
    logic [7:0] db_hold;
    logic       rs_hold;
    int         checks;
    int         fails;

    initial begin
        checks = 0;
        fails  = 0;
        n      = 0;
    end

    always @(negedge clk) begin
        if (rst) begin
            cyc  = 0;
            n    = 0;
            seen = 0;
            e_d  = 0;
            hi_w = 0;
        end else begin
            cyc++;
            if (e && !e_d) begin
                checks++;
                if (rw !== 1'b0) begin
                    fails++;
                    $display("FAIL R2 %m rw during strobe actual=%0b expected=0", rw);
                end
                if (seen) begin
                    checks++;
                    if (cyc - last_rise < SP_MIN) begin
                        fails++;
                        $display("FAIL R4 %m strobe spacing actual=%0d expected>=%0d",
                                 cyc - last_rise, SP_MIN);
                    end
                end
                if (BUS4) begin
                    checks++;
                    if (db[3:0] !== 4'h0) begin
                        fails++;
                        $display("FAIL R8 %m low lines actual=%0h expected=0", db[3:0]);
                    end
                end
                last_rise = cyc;
                seen      = 1;
                hi_w      = 0;
                db_hold   = db;
                rs_hold   = rs;
                if (n < 256) begin
                    val[n] = BUS4 ? {4'h0, db[7:4]} : db;
                    vrs[n] = rs;
                    rt[n]  = cyc;
                    n++;
                end
            end
            if (e && e_d && (db !== db_hold || rs !== rs_hold)) begin
                checks++;
                fails++;
                $display("FAIL R11 %m data moved during strobe actual=%0h expected=%0h", db, db_hold);
            end
            if (e)
                hi_w++;
            if (!e && e_d) begin
                checks++;
                if (hi_w < E_MIN) begin
                    fails++;
                    $display("FAIL R3 %m strobe width actual=%0d expected>=%0d", hi_w, E_MIN);
                end
            end
            e_d = e;
        end
    end
endmodule

module lcd_wr_ctrl_test;
    localparam int CLK_PERIOD = 1000;   // 1 MHz
    localparam int HZ         = 1_000_000;
    localparam int E_MIN      = 1;      // ceil(140 ns)
    localparam int SP_MIN     = 2;      // ceil(1200 ns)
    localparam int SHORT_W    = 37;
    localparam int LONG_W     = 1520;
    localparam int PWR_W      = 40_000;
    localparam int WATCHDOG   = 190_000;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en   [2];
    logic       wr_rs   [2];
    logic [7:0] wr_data [2];
    logic       rdy     [2];
    logic       e       [2];
    logic       rs      [2];
    logic       rw      [2];
    logic [7:0] db      [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Instance 0: 4-bit bus; instance 1: 8-bit bus with a power-up request below the floor
    lcd_wr_ctrl #(.CLK_HZ(HZ), .BUS4(1'b1), .POWERUP_US(40_000)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_rs(wr_rs[0]), .wr_data(wr_data[0]),
        .ready(rdy[0]), .lcd_e(e[0]), .lcd_rs(rs[0]), .lcd_rw(rw[0]), .lcd_db(db[0]));

    lcd_wr_ctrl #(.CLK_HZ(HZ), .BUS4(1'b0), .POWERUP_US(5_000)) uut8 (
        .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_rs(wr_rs[1]), .wr_data(wr_data[1]),
        .ready(rdy[1]), .lcd_e(e[1]), .lcd_rs(rs[1]), .lcd_rw(rw[1]), .lcd_db(db[1]));

    lcd_wr_ctrl_mon #(.BUS4(1'b1), .E_MIN(E_MIN), .SP_MIN(SP_MIN)) mon0 (
        .clk(clk), .rst(rst), .e(e[0]), .rs(rs[0]), .rw(rw[0]), .db(db[0]));
    lcd_wr_ctrl_mon #(.BUS4(1'b0), .E_MIN(E_MIN), .SP_MIN(SP_MIN)) mon1 (
        .clk(clk), .rst(rst), .e(e[1]), .rs(rs[1]), .rw(rw[1]), .db(db[1]));

    int         checks = 0;
    int         fails  = 0;
    bit         reported = 0;
    logic [7:0] ev  [2][256];
    logic       ers [2][256];
    int         eg  [2][256];
    int         en  [2];
    int         last_wait [2];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed",
                     checks + mon0.checks + mon1.checks, fails + mon0.fails + mon1.fails);
            $finish;
        end
    endtask

    function automatic bit is_long(logic r, logic [7:0] d);
        return !r && (d == 8'h01 || d == 8'h02);
    endfunction

    task automatic push(int i, logic [7:0] v, logic r, int g);
        ev[i][en[i]]  = v;
        ers[i][en[i]] = r;
        eg[i][en[i]]  = g;
        en[i]++;
    endtask

    task automatic push_nib(int i, logic [3:0] v);
        push(i, {4'h0, v}, 1'b0, last_wait[i]);
        last_wait[i] = SHORT_W;
    endtask

    task automatic push_cmd(int i, logic r, logic [7:0] d);
        if (i == 0) begin
            push(i, {4'h0, d[7:4]}, r, last_wait[i]);
            push(i, {4'h0, d[3:0]}, r, SP_MIN);
        end else begin
            push(i, d, r, last_wait[i]);
        end
        last_wait[i] = is_long(r, d) ? LONG_W : SHORT_W;
    endtask

    task automatic expect_init(int i);
        en[i]        = 0;
        last_wait[i] = PWR_W;
        if (i == 0) begin
            // R7 nibble phase then bytes
            push_nib(i, 4'h3); push_nib(i, 4'h3); push_nib(i, 4'h3); push_nib(i, 4'h2);
            push_cmd(i, 1'b0, 8'h28);
        end else begin
            // R6 byte sequence
            push_cmd(i, 1'b0, 8'h30); push_cmd(i, 1'b0, 8'h30); push_cmd(i, 1'b0, 8'h30);
            push_cmd(i, 1'b0, 8'h38);
        end
        push_cmd(i, 1'b0, 8'h0C);
        push_cmd(i, 1'b0, 8'h01);
        push_cmd(i, 1'b0, 8'h06);
    endtask

    task automatic wait_ready(int i);
        while (!rdy[i]) @(negedge clk);
    endtask

    task automatic host_write(int i, logic r, logic [7:0] d);
        int k;
        int w;
        wait_ready(i);
        push_cmd(i, r, d);
        w = is_long(r, d) ? LONG_W : SHORT_W;
        wr_en[i] = 1'b1; wr_rs[i] = r; wr_data[i] = d;
        @(negedge clk);
        wr_en[i] = 1'b0;
        chk(rdy[i] == 1'b0, "R10 ready after accept", int'(rdy[i]), 0);
        // Write presented while busy: must not reach the display (R11)
        wr_en[i] = 1'b1; wr_rs[i] = ~r; wr_data[i] = ~d;
        @(negedge clk);
        wr_en[i] = 1'b0;
        k = 2;
        while (!rdy[i]) begin
            @(negedge clk);
            k++;
        end
        chk(k >= w, "R9 ready hold-off", k, w);
    endtask

    task automatic compare(int i);
        int         n;
        logic [7:0] v;
        logic       r;
        int         g;
        int         initn;
        n     = (i == 0) ? mon0.n : mon1.n;
        initn = (i == 0) ? 12 : 7;
        chk(n == en[i], "R11 strobe count", n, en[i]);
        for (int k = 0; k < en[i] && k < n; k++) begin
            if (i == 0) begin
                v = mon0.val[k]; r = mon0.vrs[k];
                g = mon0.rt[k] - ((k == 0) ? 0 : mon0.rt[k-1]);
            end else begin
                v = mon1.val[k]; r = mon1.vrs[k];
                g = mon1.rt[k] - ((k == 0) ? 0 : mon1.rt[k-1]);
            end
            if (k < initn)
                chk(v == ev[i][k], (i == 0) ? "R7 init value" : "R6 init value", int'(v), int'(ev[i][k]));
            else
                chk(v == ev[i][k], (i == 0) ? "R8 nibble value" : "R1 byte value", int'(v), int'(ev[i][k]));
            chk(r == ers[i][k], "R1 register select", int'(r), int'(ers[i][k]));
            if (k == 0)
                chk(g >= eg[i][k], "R5 power-up gap", g, eg[i][k]);
            else if (eg[i][k] == SP_MIN)
                chk(g >= eg[i][k], "R4 nibble gap", g, eg[i][k]);
            else
                chk(g >= eg[i][k], "R9 command gap", g, eg[i][k]);
        end
    endtask

    task automatic run(int i);
        logic       r;
        logic [7:0] d;
        expect_init(i);
        repeat (20_000) @(negedge clk);
        chk(rdy[i] == 1'b0, "R5 ready during power-up", int'(rdy[i]), 0);
        chk(((i == 0) ? mon0.n : mon1.n) == 0, "R5 quiet during power-up",
            (i == 0) ? mon0.n : mon1.n, 0);
        wait_ready(i);
        // Directed corners: clear, home, data extremes, command
        host_write(i, 1'b0, 8'h01);
        host_write(i, 1'b1, 8'hA5);
        host_write(i, 1'b0, 8'h02);
        host_write(i, 1'b1, 8'h00);
        host_write(i, 1'b1, 8'hFF);
        host_write(i, 1'b1, 8'h01);
        host_write(i, 1'b0, 8'h80);
        for (int t = 0; t < 30; t++) begin
            r = 1'($urandom);
            d = 8'($urandom);
            if (!r && (d == 8'h01 || d == 8'h02))
                d = 8'h14;
            host_write(i, r, d);
        end
        wait_ready(i);
        compare(i);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd4711);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            wr_en[i] = 1'b0; wr_rs[i] = 1'b0; wr_data[i] = 8'h00;
        end
        repeat (5) @(negedge clk);
        chk(rdy[0] == 1'b0 && rdy[1] == 1'b0, "R5 ready in reset", int'(rdy[0]) + int'(rdy[1]), 0);
        chk(e[0] == 1'b0 && e[1] == 1'b0, "R11 enable in reset", int'(e[0]) + int'(e[1]), 0);
        rst = 1'b0;
        fork
            run(0);
            run(1);
        join

        // R12: reset in the middle of a 4-bit transfer
        wait_ready(0);
        wr_en[0] = 1'b1; wr_rs[0] = 1'b1; wr_data[0] = 8'h41;
        @(negedge clk);
        wr_en[0] = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rdy[0] == 1'b0 && rdy[1] == 1'b0, "R12 ready after reset", int'(rdy[0]) + int'(rdy[1]), 0);
        repeat (100) @(negedge clk);
        chk(mon0.n == 0 && mon1.n == 0, "R12 quiet after reset", mon0.n + mon1.n, 0);
        expect_init(0);
        expect_init(1);
        fork
            wait_ready(0);
            wait_ready(1);
        join
        compare(0);
        compare(1);
        report();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        report();
    end

endmodule